// File: doc/BRIEF.md
# Prioritized Core Interrupt Controller

This block gathers thirty-two interrupt sources for one processor core. It keeps a sticky pending flag, an enable flag and a four-bit priority for each source. Every cycle it chooses the most urgent request that is enabled and pending, and drives that choice to the core as a request line with the winning index and its level. The low-numbered sources follow level-sensitive hardware lines. Software can raise or drop the pending flag of any source, and can program a threshold below which requests are held back.

Software uses a small word-addressed register port. Address 0 is the enable mask. A write to address 1 raises pending flags, and a write to address 2 drops them; both addresses read back the pending word. Address 3 is the threshold. Addresses 4 and up hold the priorities, packed eight per word. The core acknowledges the source it has taken by index. That acknowledge drops the source's pending flag unless something raises it again in the same cycle.

Top module: `core_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all pending flags, enables, priorities and the threshold are zero, `irq_req` is low and `reg_rdata` is zero.
- R2: Hardware line k (k below NHW) sets pending flag k at every clock edge where it is high. The flag stays set after the line falls. A read of address 1 or 2 shows every pending flag, whether the source is enabled or not.
- R3: A write to address 1 sets each pending flag whose data bit is 1. A write to address 2 clears each pending flag whose data bit is 1. A clear has no effect on a source whose hardware line is high in the same cycle.
- R4: Address 0 holds the enable mask, with bit i for source i. A source whose enable bit is 0 never becomes the winner, and its pending flag is kept.
- R5: The priority of source i sits in the word at address 4 + i/8, bits [4*(i%8)+3 : 4*(i%8)]. These words can be written and read back.
- R6: The winner is the enabled pending source with the highest priority. Among equal priorities, the lowest index wins.
- R7: `irq_req` is high only when the winner's priority is strictly greater than the threshold held in bits [3:0] of address 3. A priority of 0 therefore never raises a request.
- R8: `ack` clears the pending flag of `ack_id`. A hardware line or a software set on the same source in the same cycle overrides the clear.
- R9: `irq_req`, `irq_id` and `irq_prio` are registered. A write, line or acknowledge captured at clock edge k changes them at edge k+1 and not earlier.
- R10: `reg_rdata` is registered. It shows the contents of address `reg_addr` as they were before edge k, and it is updated at edge k. The threshold word reads zero above bit 3.
- R11: Sources at index NHW and above have no hardware line and can be raised only by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | NHW | Level-sensitive hardware lines for sources 0 to NHW-1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ack | input | 1 | Core acknowledges a source |
| ack_id | input | 5 | Index of the acknowledged source |
| irq_req | output | 1 | Request to the core |
| irq_id | output | 5 | Index of the current winner |
| irq_prio | output | 4 | Priority of the current winner |

## Verification
Two functions can land on the same pending flag in one cycle. One is the acknowledge or a software clear. The other is a hardware line or a software set. The bench forces both orders on purpose. It acknowledges source 1 while its line is held high, it acknowledges source 1 in the cycle that software sets it, and it clears source 0 while line 0 is high. In each case it checks that the flag survives and that the request returns one cycle later. A long random phase then mixes writes, line pulses and acknowledges of the live winner. There, a behavioural model running beside the design judges every cycle.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  // register word addresses; priority words follow from PRIO_BASE upward
  localparam int unsigned ADDR_EN    = 0;
  localparam int unsigned ADDR_SET   = 1;
  localparam int unsigned ADDR_CLR   = 2;
  localparam int unsigned ADDR_THR   = 3;
  localparam int unsigned PRIO_BASE  = 4;
endpackage

// File: rtl/core_irq_regs.sv
module core_irq_regs
  import core_irq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int PW   = 4,
  parameter int AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [NSRC-1:0]      wdata,
  input  logic [NSRC-1:0]      pend_q,
  output logic [NSRC-1:0]      en_q,
  output logic [PW-1:0]        thr_q,
  output logic [NSRC*PW-1:0]   prio_q,
  output logic [NSRC-1:0]      sw_set,
  output logic [NSRC-1:0]      sw_clr,
  output logic [NSRC-1:0]      rdata
);
  localparam int DW  = NSRC;
  localparam int SPW = DW / PW;     // sources per priority word
  localparam int NPW = NSRC / SPW;  // number of priority words

  logic          hit_en, hit_thr, hit_prio;
  logic [AW-1:0] widx;
  logic [DW-1:0] rd_n;

  always_comb begin
    widx     = addr - AW'(PRIO_BASE);
    hit_en   = (addr == AW'(ADDR_EN));
    hit_thr  = (addr == AW'(ADDR_THR));
    hit_prio = (addr >= AW'(PRIO_BASE)) && (int'(widx) < NPW);
    sw_set   = (wr && addr == AW'(ADDR_SET)) ? wdata : '0;
    sw_clr   = (wr && addr == AW'(ADDR_CLR)) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      thr_q  <= '0;
      prio_q <= '0;
    end else if (wr) begin
      if (hit_en)   en_q  <= wdata;
      if (hit_thr)  thr_q <= wdata[PW-1:0];
      if (hit_prio) prio_q[int'(widx)*DW +: DW] <= wdata;
    end
  end

  always_comb begin
    rd_n = '0;
    if (hit_en)
      rd_n = en_q;
    else if (addr == AW'(ADDR_SET) || addr == AW'(ADDR_CLR))
      rd_n = pend_q;
    else if (hit_thr)
      rd_n = {{(DW-PW){1'b0}}, thr_q};
    else if (hit_prio)
      rd_n = prio_q[int'(widx)*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  // R4
  en_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(ADDR_EN)) |=> (en_q == $past(wdata)));

  // R7
  thr_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == AW'(ADDR_THR)) |=> (thr_q == $past(wdata[PW-1:0])));
endmodule

// File: rtl/core_irq_pending.sv
module core_irq_pending #(
  parameter int NSRC = 32,
  parameter int NHW  = 8,
  parameter int IDW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NHW-1:0]  hw_irq,
  input  logic [NSRC-1:0] sw_set,
  input  logic [NSRC-1:0] sw_clr,
  input  logic            ack,
  input  logic [IDW-1:0]  ack_id,
  output logic [NSRC-1:0] pend_q
);
  logic [NSRC-1:0] hw_vec;
  logic [NSRC-1:0] ack_vec;
  logic [NSRC-1:0] raise;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < NHW) begin : g_wired
      assign hw_vec[i] = hw_irq[i];
    end else begin : g_soft
      assign hw_vec[i] = 1'b0;
    end
    assign ack_vec[i] = ack && (ack_id == IDW'(i));
  end

  // raising beats clearing on the same source in the same cycle
  assign raise = sw_set | hw_vec;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~(sw_clr | ack_vec)) | raise;
  end

  // R2
  hw_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|hw_vec) |=> ((pend_q & $past(hw_vec)) == $past(hw_vec)));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !raise[ack_id]) |=> !pend_q[$past(ack_id)]);
endmodule

// File: rtl/core_irq_arbiter.sv
module core_irq_arbiter #(
  parameter int NSRC = 32,
  parameter int PW   = 4,
  parameter int IDW  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    pend_q,
  input  logic [NSRC-1:0]    en_q,
  input  logic [NSRC*PW-1:0] prio_q,
  input  logic [PW-1:0]      thr_q,
  output logic               irq_req,
  output logic [IDW-1:0]     irq_id,
  output logic [PW-1:0]      irq_prio
);
  // NSRC must be a power of two for the pairwise reduction
  localparam int LG = $clog2(NSRC);

  logic [PW-1:0]  cand_p [NSRC];
  logic [PW-1:0]  tp     [NSRC];
  logic [IDW-1:0] ti     [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_cand
    assign cand_p[i] = (pend_q[i] && en_q[i]) ? prio_q[i*PW +: PW] : '0;
  end

  // in-place pairwise reduction; the upper half wins only when strictly higher
  always_comb begin
    for (int n = 0; n < NSRC; n++) begin
      tp[n] = cand_p[n];
      ti[n] = IDW'(n);
    end
    for (int l = 0; l < LG; l++) begin
      for (int n = 0; n < NSRC/2; n++) begin
        if (n < (NSRC >> (l+1))) begin
          if (tp[2*n+1] > tp[2*n]) begin
            tp[n] = tp[2*n+1];
            ti[n] = ti[2*n+1];
          end else begin
            tp[n] = tp[2*n];
            ti[n] = ti[2*n];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_id   <= '0;
      irq_prio <= '0;
    end else begin
      irq_req  <= (tp[0] > thr_q);
      irq_id   <= ti[0];
      irq_prio <= tp[0];
    end
  end

  // R7
  above_thr_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_prio > $past(thr_q)));

  for (genvar i = 0; i < NSRC; i++) begin : g_max
    // R6
    winner_max_chk: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> ($past(cand_p[i]) <= irq_prio));
  end
endmodule

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl
  import core_irq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int PW   = 4,
  parameter int NHW  = 8,
  localparam int IDW = $clog2(NSRC),
  localparam int NPW = (NSRC * PW) / NSRC,
  localparam int AW  = $clog2(PRIO_BASE + NPW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NHW-1:0]  hw_irq,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  input  logic            ack,
  input  logic [IDW-1:0]  ack_id,
  output logic            irq_req,
  output logic [IDW-1:0]  irq_id,
  output logic [PW-1:0]   irq_prio
);
  logic [NSRC-1:0]    pend_q, en_q, sw_set, sw_clr;
  logic [PW-1:0]      thr_q;
  logic [NSRC*PW-1:0] prio_q;

  core_irq_regs #(.NSRC(NSRC), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pend_q(pend_q), .en_q(en_q), .thr_q(thr_q), .prio_q(prio_q),
    .sw_set(sw_set), .sw_clr(sw_clr), .rdata(reg_rdata)
  );

  core_irq_pending #(.NSRC(NSRC), .NHW(NHW), .IDW(IDW)) u_pend (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .sw_set(sw_set), .sw_clr(sw_clr),
    .ack(ack), .ack_id(ack_id), .pend_q(pend_q)
  );

  core_irq_arbiter #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_arb (
    .clk(clk), .rst(rst), .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q),
    .thr_q(thr_q), .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio)
  );
endmodule

// File: tb/core_irq_ctrl_bench.sv
module core_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  hw_irq = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ack = 1'b0;
  logic [4:0]  ack_id = '0;
  logic        irq_req;
  logic [4:0]  irq_id;
  logic [3:0]  irq_prio;

  int tests = 0, fails = 0, cyc = 0;
  bit started = 0, done = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  core_irq_ctrl u_core_irq_ctrl (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack), .ack_id(ack_id),
    .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio)
  );

  // behavioural reference model
  logic [31:0] m_pend = '0, m_en = '0;
  logic [3:0]  m_prio [32];
  logic [3:0]  m_thr = '0;
  logic        e_req = 0;
  logic [4:0]  e_id = '0;
  logic [3:0]  e_prio = '0;
  logic [31:0] e_rdata = '0;

  initial for (int i = 0; i < 32; i++) m_prio[i] = '0;

  always @(posedge clk) begin : model
    int best, bid, k;
    logic [31:0] setv, clrv, w;
    started <= 1;
    if (rst) begin
      m_pend <= '0; m_en <= '0; m_thr <= '0;
      for (int i = 0; i < 32; i++) m_prio[i] <= '0;
      e_req <= 0; e_id <= '0; e_prio <= '0; e_rdata <= '0;
    end else begin
      best = 0; bid = 0;
      for (int i = 0; i < 32; i++)
        if (m_pend[i] && m_en[i] && int'(m_prio[i]) > best) begin
          best = int'(m_prio[i]); bid = i;
        end
      e_req  <= (best > int'(m_thr));
      e_id   <= 5'(bid);
      e_prio <= 4'(best);
      case (reg_addr)
        3'd0: w = m_en;
        3'd1, 3'd2: w = m_pend;
        3'd3: w = {28'b0, m_thr};
        default: begin
          k = int'(reg_addr) - 4;
          for (int j = 0; j < 8; j++) w[j*4 +: 4] = m_prio[k*8+j];
        end
      endcase
      e_rdata <= w;
      setv = '0; clrv = '0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_en <= reg_wdata;
          3'd1: setv = reg_wdata;
          3'd2: clrv = reg_wdata;
          3'd3: m_thr <= reg_wdata[3:0];
          default: begin
            k = int'(reg_addr) - 4;
            for (int j = 0; j < 8; j++) m_prio[k*8+j] <= reg_wdata[j*4 +: 4];
          end
        endcase
      end
      if (ack) clrv[ack_id] = 1'b1;
      m_pend <= (m_pend & ~clrv) | setv | {24'b0, hw_irq};
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      tests++;
      if ({irq_req, irq_id, irq_prio, reg_rdata} != {e_req, e_id, e_prio, e_rdata}) begin
        fails++;
        $display("FAIL %s model: got req=%0d id=%0d prio=%0d rdata=%h expected req=%0d id=%0d prio=%0d rdata=%h",
                 phase, irq_req, irq_id, irq_prio, reg_rdata, e_req, e_id, e_prio, e_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    chk("R1 req", {31'b0, irq_req}, 32'h0);
    chk("R1 rdata", reg_rdata, 32'h0);

    // R5 priority words: src1=3, src9=5, src20=5, src31=7
    phase = "R5";
    do_wr(3'd4, 32'h0000_0030);
    do_wr(3'd5, 32'h0000_0050);
    do_wr(3'd6, 32'h0005_0000);
    do_wr(3'd7, 32'h7000_0000);
    reg_addr = 3'd6;
    idle(1);
    chk("R5 R10 readback word 6", reg_rdata, 32'h0005_0000);

    // R2 hardware pulse on line 1, then status readback
    phase = "R2";
    do_wr(3'd0, 32'hFFFF_FFFF);
    reg_addr = 3'd1;
    hw_irq = 8'h02;
    idle(1);
    hw_irq = 8'h00;
    idle(1);
    chk("R2 req", {31'b0, irq_req}, 32'h1);
    chk("R2 id", {27'b0, irq_id}, 32'd1);
    chk("R2 pending status", reg_rdata, 32'h2);

    // R4 / R9 disable source 1
    phase = "R4";
    do_wr(3'd0, 32'hFFFF_FFFD);
    chk("R9 output unchanged one edge after write", {31'b0, irq_req}, 32'h1);
    reg_addr = 3'd1;
    idle(1);
    chk("R4 disabled source loses", {31'b0, irq_req}, 32'h0);
    chk("R4 pending kept while disabled", reg_rdata, 32'h2);

    // R6 priority order and tie break
    phase = "R6";
    do_wr(3'd1, (32'h1 << 9) | (32'h1 << 20));
    idle(1);
    chk("R6 tie goes to lower index", {27'b0, irq_id}, 32'd9);
    chk("R6 tie prio", {28'b0, irq_prio}, 32'd5);
    do_wr(3'd1, 32'h8000_0000);
    idle(1);
    chk("R6 higher priority wins", {27'b0, irq_id}, 32'd31);
    do_wr(3'd2, 32'h8000_0000);
    idle(1);
    chk("R3 software clear", {27'b0, irq_id}, 32'd9);

    // R7 threshold and zero priority
    phase = "R7";
    do_wr(3'd3, 32'h5);
    idle(1);
    chk("R7 equal to threshold holds back", {31'b0, irq_req}, 32'h0);
    do_wr(3'd3, 32'h4);
    idle(1);
    chk("R7 above threshold requests", {31'b0, irq_req}, 32'h1);
    do_wr(3'd3, 32'h0);
    do_wr(3'd2, (32'h1 << 9) | (32'h1 << 20));
    do_wr(3'd1, 32'h8);
    idle(1);
    chk("R7 priority zero never requests", {31'b0, irq_req}, 32'h0);

    // R8 acknowledge and collisions
    phase = "R8";
    do_wr(3'd0, 32'hFFFF_FFFF);
    idle(1);
    chk("R8 winner before ack", {27'b0, irq_id}, 32'd1);
    ack = 1; ack_id = 5'd1;
    idle(1);
    ack = 0;
    idle(1);
    chk("R8 ack clears", {31'b0, irq_req}, 32'h0);
    hw_irq = 8'h02; ack = 1; ack_id = 5'd1;
    idle(1);
    hw_irq = 8'h00; ack = 0;
    idle(1);
    chk("R8 line high overrides ack", {31'b0, irq_req}, 32'h1);
    ack = 1; ack_id = 5'd1;
    do_wr(3'd1, 32'h2);
    ack = 0;
    idle(1);
    chk("R8 software set overrides ack", {27'b0, irq_id}, 32'd1);
    ack = 1; ack_id = 5'd1;
    idle(1);
    ack = 0;
    do_wr(3'd2, 32'h8);

    // R3 clear while line high
    phase = "R3";
    hw_irq = 8'h01;
    do_wr(3'd2, 32'h1);
    hw_irq = 8'h00;
    reg_addr = 3'd1;
    idle(1);
    chk("R3 clear loses to active line", reg_rdata, 32'h1);
    do_wr(3'd2, 32'h1);

    // R11 top hardware line maps to its own source only
    phase = "R11";
    reg_addr = 3'd1;
    hw_irq = 8'h80;
    idle(1);
    hw_irq = 8'h00;
    idle(1);
    chk("R11 line 7 sets only source 7", reg_rdata, 32'h80);

    // R10 readback of threshold and last priority word
    phase = "R10";
    reg_addr = 3'd3;
    idle(1);
    chk("R10 threshold word", reg_rdata, 32'h0);
    reg_addr = 3'd7;
    idle(1);
    chk("R10 priority word 7", reg_rdata, 32'h7000_0000);

    // random mix judged by the model each cycle (R3 R6 R8 R9)
    phase = "R3";
    for (int c = 0; c < 4000; c++) begin
      reg_wr    = (($urandom % 4) == 0);
      reg_addr  = 3'($urandom % 8);
      reg_wdata = $urandom;
      if (reg_wr && reg_addr == 3'd3) reg_wdata[3:0] = 4'($urandom % 4);
      hw_irq    = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      ack       = (($urandom % 3) == 0);
      ack_id    = ($urandom % 2) ? irq_id : 5'($urandom);
      @(negedge clk);
    end
    reg_wr = 0; hw_irq = '0; ack = 0;
    idle(2);
    finish_run();
  end
endmodule